// File: doc/BRIEF.md
# Counter-Based Start Trigger Generator

This block produces start triggers for a group of pulse-generator channels from a single shared 8-bit up counter. Software sets a clock divider, gives each trigger channel an 8-bit compare value, and then starts the counter. The counter sweeps from 0 to 0xFF, advancing once per prescaled tick, and then halts by itself. While it runs, a channel whose compare value equals the counter raises its trigger line. The line stays HIGH until software writes a clear to it.

Everything is accessed through a single-cycle write strobe and a combinational read port. The control word at address 0 holds the divider select, the start command, the running flag and one clear bit per channel. Address 1+i holds the compare value of channel i. Compare values and the divider select are locked while the counter runs. This keeps a sweep consistent from start to finish.

Top module: `start_trig_unit`

## Requirements
- R1: A synchronous active-high reset stops the counter and sets the divider select to 00. It sets every compare value to 0 and drives every trigger output LOW. After reset, the control word reads running=0 and start=0, and every clear bit reads 1.
- R2: The divider select sits in control bits [1:0]. The encodings 00, 01, 10 and 11 make the counter advance once every 2, 8, 32 and 64 clock cycles.
- R3: Writing 1 to control bit 2 (start) while the counter is stopped loads the counter with 0 and starts it. Writing 0 to that bit has no effect, and the bit always reads 0.
- R4: A start write received while the counter is running is ignored and does not restart the sweep.
- R5: Control bit 3 is a read-only running flag. It reads 1 from the start write until the prescaled tick that arrives while the counter holds 0xFF, and 0 after that.
- R6: When the running counter equals a channel's compare value (address 1+i, bits [7:0]), that channel's trigger goes HIGH one cycle later. It stays HIGH after the counter moves on.
- R7: A channel whose compare value is 0 never raises its trigger.
- R8: Writing 0 to control bit 4+i forces trigger i LOW on the next cycle. Writing 1 there has no effect, and these bits always read 1.
- R9: When a clear and a compare match hit the same channel in the same cycle, the clear wins and the trigger stays LOW.
- R10: While the counter runs, writes to the compare registers and to the divider select are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Register address for both read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| trig_o | output | NUM_CH | Sticky start trigger per channel |

## Verification
Every result has a fixed cycle count from the start write, taken as edge 0:
- A channel with compare value c and divider D raises its trigger after edge c*D+1.
- The running flag drops after edge 256*D.
- A clear takes effect after the write edge itself.

The bench drives and samples on falling edges and steps an exact number of edges before each check. Each timed check samples one cycle before the due edge, expecting the old value, and then again right after it. Ignored writes, such as a restart, a locked compare value or a locked divider, are caught through a later trigger timing or a read-back.

// File: rtl/stu_pkg.sv
package stu_pkg;

    localparam int CNT_W      = 8;
    localparam int SEL_W      = 2;
    localparam int PRE_W      = 6;

    // control word field positions
    localparam int F_SEL_LSB  = 0;
    localparam int F_START    = 2;
    localparam int F_RUN      = 3;
    localparam int F_CLR_LSB  = 4;

    typedef enum logic [SEL_W-1:0] {
        DIV_2  = 2'b00,
        DIV_8  = 2'b01,
        DIV_32 = 2'b10,
        DIV_64 = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic     hit;
        logic     start;
        logic     sel_we;
        clk_sel_e sel;
    } ctrl_wr_t;

    // terminal value of the prescaler for a given divider select
    function automatic logic [PRE_W-1:0] pre_limit(clk_sel_e sel);
        case (sel)
            DIV_2:   pre_limit = PRE_W'(1);
            DIV_8:   pre_limit = PRE_W'(7);
            DIV_32:  pre_limit = PRE_W'(31);
            default: pre_limit = PRE_W'(63);
        endcase
    endfunction

endpackage

// File: rtl/stu_prescaler.sv
module stu_prescaler
    import stu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_sel_e sel,
    output logic     tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    assign lim  = pre_limit(sel);
    assign tick = run && (pre_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (pre_q == lim) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2: the smallest divider is 2, so two ticks never fall on adjacent cycles
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/stu_upcounter.sv
module stu_upcounter
    import stu_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         tick,
    output logic         running,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= '0;
        end else if (!running && start_req) begin
            running <= 1'b1;
            count   <= '0;
        end else if (running && tick) begin
            if (count == TOP) begin
                running <= 1'b0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    // R4: a start request during a sweep leaves the count alone
    p_restart_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (running && start_req && !tick) |=> $stable(count));

    // R5: a tick at the top value ends the sweep
    p_sweep_end_r5: assert property (@(posedge clk) disable iff (rst)
        (running && tick && count == TOP) |=> !running);

    // R3: a start from idle begins at zero
    p_start_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!running && start_req) |=> (running && count == '0));

endmodule

// File: rtl/stu_trig_chan.sv
module stu_trig_chan
    import stu_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         running,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic         clr,
    output logic         trig
);

    logic match;

    assign match = running && (cmp != '0) && (count == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig <= 1'b0;
        end else if (clr) begin
            trig <= 1'b0;
        end else if (match) begin
            trig <= 1'b1;
        end
    end

    // R9: a clear beats any match in the same cycle
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !trig);

    // R6: a raised trigger holds until cleared
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (trig && !clr) |=> trig);

    // R7: a zero compare value never raises the line
    p_zero_cmp_r7: assert property (@(posedge clk) disable iff (rst)
        (!trig && cmp == '0) |=> !trig);

endmodule

// File: rtl/start_trig_unit.sv
module start_trig_unit
    import stu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] trig_o
);

    logic                         running;
    logic [CNT_W-1:0]             count;
    logic                         tick;
    clk_sel_e                     sel_q;
    ctrl_wr_t                     cw;
    logic [NUM_CH-1:0]            clr;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
    logic                         unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // control-word write decode
    always_comb begin
        cw.hit    = bus_we && (bus_addr == '0);
        cw.start  = cw.hit && bus_wdata[F_START];
        cw.sel_we = cw.hit && !running;
        cw.sel    = clk_sel_e'(bus_wdata[F_SEL_LSB +: SEL_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= DIV_2;
        end else if (cw.sel_we) begin
            sel_q <= cw.sel;
        end
    end

    stu_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .sel  (sel_q),
        .tick (tick)
    );

    stu_upcounter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start_req (cw.start),
        .tick      (tick),
        .running   (running),
        .count     (count)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic cmp_we;

        assign cmp_we = bus_we && !running && (bus_addr == ADDR_W'(i + 1));
        assign clr[i] = cw.hit && !bus_wdata[F_CLR_LSB + i];

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[i] <= '0;
            end else if (cmp_we) begin
                cmp_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end

        stu_trig_chan #(.W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .running (running),
            .count   (count),
            .cmp     (cmp_q[i]),
            .clr     (clr[i]),
            .trig    (trig_o[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) begin
            bus_rdata[F_SEL_LSB +: SEL_W]  = sel_q;
            bus_rdata[F_RUN]               = running;
            bus_rdata[F_CLR_LSB +: NUM_CH] = '1;
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (bus_addr == ADDR_W'(k + 1)) begin
                    bus_rdata[CNT_W-1:0] = cmp_q[k];
                end
            end
        end
    end

    // R10: compare values stay fixed while a sweep is in progress
    p_cmp_locked_r10: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(cmp_q));

    // R10: divider select stays fixed while a sweep is in progress
    p_sel_locked_r10: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(sel_q));

endmodule

// File: tb/start_trig_unit_tb.sv
module start_trig_unit_tb;

    localparam int CLK_P  = 10;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_CH-1:0] trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    start_trig_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_o(trig_o)
    );

    function automatic logic [DATA_W-1:0] ctl(logic [1:0] sel, logic start, logic [3:0] keep);
        return DATA_W'({keep, 1'b0, start, sel});
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        bus_we = 0; bus_addr = '0; bus_wdata = '0;
        rst = 1; step(2); rst = 0;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        step(1);
        bus_we = 0; bus_addr = '0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = '0;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        do_reset();
        check(trig_o == '0, "R1 trig", trig_o, 0);
        rd(0, d);
        check(d == 16'h00F0, "R1 ctrl", d, 16'h00F0);
        rd(2, d);
        check(d == 0, "R1 cmp", d, 0);
        wr(0, ctl(2'b00, 1'b0, 4'hF));
        rd(0, d);
        check(d[3] == 0 && d[2] == 0, "R3 start0 no effect", d, 16'h00F0);
    endtask

    task automatic t_sweep();
        logic [DATA_W-1:0] d;
        do_reset();
        wr(1, 3); wr(2, 0); wr(3, 10);
        wr(0, ctl(2'b00, 1'b1, 4'hF));          // start edge E0
        rd(0, d);
        check(d[3] == 1 && d[2] == 0, "R3/R5 running", d, 16'h00F8);
        step(6);                                // after E6
        check(trig_o[0] == 0, "R6 early", trig_o, 0);
        step(1);                                // after E7
        check(trig_o[0] == 1, "R6 rise", trig_o[0], 1);
        step(8);                                // after E15
        wr(0, ctl(2'b00, 1'b1, 4'hF));          // restart attempt at E16
        step(4);                                // after E20
        check(trig_o[2] == 0, "R4 early", trig_o[2], 0);
        step(1);                                // after E21
        check(trig_o[2] == 1, "R4 no restart", trig_o[2], 1);
        check(trig_o[0] == 1, "R6 sticky", trig_o[0], 1);
        check(trig_o[1] == 0, "R7 zero cmp", trig_o[1], 0);
        wr(4, 8'h55);
        wr(0, ctl(2'b11, 1'b0, 4'hF));
        rd(4, d);
        check(d == 0, "R10 cmp locked", d, 0);
        rd(0, d);
        check(d[1:0] == 2'b00, "R10 sel locked", d[1:0], 0);
        wr(0, ctl(2'b00, 1'b0, 4'b1110));       // clear ch0 only
        check(trig_o == 4'b0100, "R8 clear", trig_o, 4'b0100);
        rd(0, d);
        check(d[7:4] == 4'hF, "R8 read ones", d[7:4], 4'hF);
    endtask

    task automatic t_run_end();
        logic [DATA_W-1:0] d;
        do_reset();
        wr(0, ctl(2'b00, 1'b1, 4'hF));          // E0
        step(511);
        rd(0, d);
        check(d[3] == 1, "R5 still running", d[3], 1);
        step(1);                                // after E512
        rd(0, d);
        check(d[3] == 0, "R5 stopped", d[3], 0);
        check(trig_o == 0, "R7 all zero cmp", trig_o, 0);
    endtask

    task automatic t_clear_wins();
        do_reset();
        wr(1, 1);
        wr(0, ctl(2'b00, 1'b1, 4'hF));          // E0
        step(2);                                // after E2
        bus_addr = 0; bus_wdata = ctl(2'b00, 1'b0, 4'b1110); bus_we = 1;
        step(2);                                // clear held over E3 and E4
        bus_we = 0;
        check(trig_o[0] == 0, "R9 clear wins", trig_o[0], 0);
        step(1);
        check(trig_o[0] == 0, "R9 after match", trig_o[0], 0);
    endtask

    task automatic t_div(logic [1:0] sel, int c, int dv);
        do_reset();
        wr(2, c);
        wr(0, ctl(sel, 1'b1, 4'hF));            // E0
        step(c * dv);
        check(trig_o[1] == 0, "R2 before", trig_o[1], 0);
        step(1);
        check(trig_o[1] == 1, "R2 at match", trig_o[1], 1);
    endtask

    task automatic t_reset_midrun();
        logic [DATA_W-1:0] d;
        do_reset();
        wr(1, 1);
        wr(0, ctl(2'b00, 1'b1, 4'hF));
        step(5);
        do_reset();
        check(trig_o == 0, "R1 midrun trig", trig_o, 0);
        rd(0, d);
        check(d == 16'h00F0, "R1 midrun ctrl", d, 16'h00F0);
    endtask

    initial begin
        step(1);
        t_reset();
        t_sweep();
        t_run_end();
        t_clear_wins();
        t_div(2'b01, 2, 8);
        t_div(2'b10, 1, 32);
        t_div(2'b11, 1, 64);
        t_reset_midrun();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule